// File: doc/BRIEF.md
# Serial Flash Sector Erase Command Decoder

This block is the device-side command front end of a serial NOR flash, limited to sector erase and the two commands that erase depends on: write enable and status read. The chip-select, serial clock and data pins are oversampled by the system clock. Each rising edge of the serial clock while chip select is low shifts in one bit in single-line mode, or one nibble in four-line mode. When chip select rises, the decoder looks at the opcode, the number of bits received, the write enable latch and the block protect setting. From these it decides whether an erase may start.

An accepted erase emits a one-cycle `erase_start` pulse carrying the 4 KB sector number, in place of a real memory array. It clears the write enable latch and holds a busy flag for a programmable number of clock cycles. While busy, the decoder answers only status reads. A status read streams a live status byte back for as long as chip select stays low.

Top module: `flash_sector_erase`

## Requirements
- R1: A frame is sampled on rising edges of `sclk` while `cs_n` is low. With `qpi_en`=0, each edge takes one bit from `io_in[0]`. With `qpi_en`=1, each edge takes four bits, with `io_in[3]` as the most significant. All values are sent most significant bit first. Erase is opcode 0x20 followed by a 24-bit address.
- R2: An erase is performed only if the write enable latch is set. The latch is set by a frame of exactly 8 bits holding opcode 0x06.
- R3: An erase frame is acted on only if `cs_n` rises after exactly 32 bits. Shorter or longer frames are discarded and leave the latch unchanged.
- R4: An accepted erase drives `erase_start` high for one cycle, with `erase_sector` equal to address bits [23:12]. Any address inside a sector selects the same sector.
- R5: The busy (WIP) flag rises with the accepted erase and stays high for exactly ERASE_CYCLES clock cycles before returning to 0.
- R6: The write enable latch is cleared when an erase is accepted.
- R7: While busy, every command except status read is ignored. A write enable sent during an erase leaves the latch at 0.
- R8: With `bp`=0, no sector is protected. With a nonzero `bp`, the top 2^(bp-1) sectors of the 4096 are protected, and all sectors are protected once bp-1 ≥ 12. An erase aimed at a protected sector is ignored and the latch keeps its value.
- R9: Opcode 0x05 starts a status read after its last opcode bit. The status byte is {0, bp[4:0], WEL, WIP}, with WIP in bit 0, WEL in bit 1 and bp in bits 6..2. It is sent most significant first and changes after each `sclk` rising edge. In single-line mode it appears on `io_out[1]`, with `io_oe`=4'b0010. In four-line mode it appears as nibbles on `io_out[3:0]`, with `io_oe`=4'hF. The byte is re-sampled and repeated while `cs_n` stays low.
- R10: After reset, WEL=0, WIP=0, `io_oe`=0 and `erase_start`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| io_in | input | 4 | Data pins in; only bit 0 is used in single-line mode |
| qpi_en | input | 1 | 1 selects four-line transfers |
| bp | input | 5 | Block protect level |
| io_out | output | 4 | Data pins out during a status read |
| io_oe | output | 4 | Output enable per data pin |
| erase_start | output | 1 | One-cycle pulse when an erase begins |
| erase_sector | output | 12 | Sector number for the erase |

## Verification
Erase frames are sent in both line modes with random addresses and random protect levels. This separates correct bit and nibble ordering from a swapped or truncated shift path. Directed frames cut one address byte short or carry one extra bit, which shows whether the exact-length rule is enforced. Sectors just inside and just outside a protected region probe the protection boundary. Status reads taken before, during and after an erase show the latch being set and cleared and the busy flag's lifetime. A write enable sent during an erase shows the busy lockout.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    localparam int OPC_BITS = 8;
    localparam int NIBBLE   = 4;

    typedef enum logic [7:0] {
        OPC_WREN   = 8'h06,
        OPC_RDSR   = 8'h05,
        OPC_SERASE = 8'h20
    } opcode_e;

    typedef struct packed {
        logic       rsvd;
        logic [4:0] bp;
        logic       wel;
        logic       wip;
    } status_t;

    typedef struct packed {
        logic       cs_n;
        logic       sclk;
        logic [3:0] io;
    } pins_t;

    // Protection: nonzero level protects the top 2^(level-1) sectors.
    function automatic logic sector_locked(input logic [31:0] sector,
                                           input int unsigned sect_log2,
                                           input logic [4:0] level);
        logic [31:0] span_log2;
        if (level == 5'd0) return 1'b0;
        span_log2 = 32'(level) - 32'd1;
        if (span_log2 >= 32'(sect_log2)) return 1'b1;
        return sector >= ((32'd1 << sect_log2) - (32'd1 << span_log2));
    endfunction

endpackage

// File: rtl/sfe_pin_sync.sv
module sfe_pin_sync
    import sfe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pins_t      pins,
    output logic       cs_low,
    output logic       cs_rise,
    output logic       cs_fall,
    output logic       sclk_rise,
    output logic [3:0] io_s
);
    localparam pins_t IDLE = '{cs_n: 1'b1, sclk: 1'b0, io: 4'h0};

    pins_t s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= IDLE;
            s2 <= IDLE;
            s3 <= IDLE;
        end else begin
            s1 <= pins;
            s2 <= s1;
            s3 <= s2;
        end
    end

    always_comb begin
        cs_low    = ~s2.cs_n;
        cs_rise   = s2.cs_n & ~s3.cs_n;
        cs_fall   = ~s2.cs_n & s3.cs_n;
        sclk_rise = s2.sclk & ~s3.sclk & ~s2.cs_n;
        io_s      = s2.io;
    end
endmodule

// File: rtl/sfe_cmd_shift.sv
module sfe_cmd_shift
    import sfe_pkg::*;
#(
    parameter int FRAME_BITS = 32,
    parameter int CNT_W      = 6,
    parameter int CNT_CAP    = 40
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  qpi,
    input  logic                  cs_fall,
    input  logic                  sclk_rise,
    input  logic [3:0]            io_s,
    output logic [FRAME_BITS-1:0] bits,
    output logic [CNT_W-1:0]      nbits,
    output logic                  rd_start
);
    logic [FRAME_BITS-1:0] bits_nx;
    logic [CNT_W-1:0]      step, cnt_nx;

    always_comb begin
        bits_nx = qpi ? {bits[FRAME_BITS-NIBBLE-1:0], io_s}
                      : {bits[FRAME_BITS-2:0], io_s[0]};
        step    = qpi ? CNT_W'(NIBBLE) : CNT_W'(1);
        cnt_nx  = (nbits < CNT_W'(CNT_CAP)) ? nbits + step : nbits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits     <= '0;
            nbits    <= '0;
            rd_start <= 1'b0;
        end else begin
            rd_start <= 1'b0;
            if (cs_fall) begin
                bits  <= '0;
                nbits <= '0;
            end else if (sclk_rise) begin
                bits     <= bits_nx;
                nbits    <= cnt_nx;
                rd_start <= (cnt_nx == CNT_W'(OPC_BITS)) &&
                            (bits_nx[OPC_BITS-1:0] == OPC_RDSR);
            end
        end
    end
endmodule

// File: rtl/sfe_status_tx.sv
module sfe_status_tx
    import sfe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       qpi,
    input  logic       rd_start,
    input  logic       cs_low,
    input  logic       sclk_rise,
    input  status_t    status,
    output logic [3:0] io_out,
    output logic [3:0] io_oe
);
    logic       active;
    logic [7:0] sh;
    logic [2:0] sent;
    logic [2:0] step;

    assign step = qpi ? 3'd4 : 3'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sh     <= '0;
            sent   <= '0;
        end else if (!cs_low) begin
            active <= 1'b0;
        end else if (rd_start) begin
            active <= 1'b1;
            sh     <= status;
            sent   <= '0;
        end else if (active && sclk_rise) begin
            if (sent + step == 3'd0) begin
                sh   <= status;
                sent <= '0;
            end else begin
                sh   <= qpi ? {sh[3:0], 4'h0} : {sh[6:0], 1'b0};
                sent <= sent + step;
            end
        end
    end

    always_comb begin
        io_out = 4'h0;
        io_oe  = 4'h0;
        if (active) begin
            if (qpi) begin
                io_out = sh[7:4];
                io_oe  = 4'hF;
            end else begin
                io_out = {2'b00, sh[7], 1'b0};
                io_oe  = 4'b0010;
            end
        end
    end
endmodule

// File: rtl/sfe_erase_ctrl.sv
module sfe_erase_ctrl
    import sfe_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int SECT_W       = 12,
    parameter int ERASE_CYCLES = 2000,
    parameter int FRAME_BITS   = 32,
    parameter int CNT_W        = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_rise,
    input  logic [FRAME_BITS-1:0] bits,
    input  logic [CNT_W-1:0]      nbits,
    input  logic [4:0]            bp,
    output logic                  wel,
    output logic                  busy,
    output logic                  erase_start,
    output logic [SECT_W-1:0]     erase_sector
);
    localparam int TMR_W = $clog2(ERASE_CYCLES + 1);

    logic [TMR_W-1:0]  timer;
    logic [SECT_W-1:0] target;
    logic              is_wren, is_erase;

    always_comb begin
        target   = bits[ADDR_W-1 -: SECT_W];
        is_wren  = (nbits == CNT_W'(OPC_BITS)) && (bits[OPC_BITS-1:0] == OPC_WREN);
        is_erase = (nbits == CNT_W'(FRAME_BITS)) &&
                   (bits[FRAME_BITS-1 -: OPC_BITS] == OPC_SERASE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wel          <= 1'b0;
            busy         <= 1'b0;
            timer        <= '0;
            erase_start  <= 1'b0;
            erase_sector <= '0;
        end else begin
            erase_start <= 1'b0;
            if (busy) begin
                timer <= timer - 1'b1;
                if (timer == TMR_W'(1)) busy <= 1'b0;
            end else if (cs_rise) begin
                if (is_wren) wel <= 1'b1;
                if (is_erase && wel &&
                    !sector_locked(32'(target), SECT_W, bp)) begin
                    erase_start  <= 1'b1;
                    erase_sector <= target;
                    busy         <= 1'b1;
                    timer        <= TMR_W'(ERASE_CYCLES);
                    wel          <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/flash_sector_erase.sv
module flash_sector_erase
    import sfe_pkg::*;
#(
    parameter int ADDR_W           = 24,
    parameter int SECTOR_ADDR_BITS = 12,
    parameter int ERASE_CYCLES     = 2000
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cs_n,
    input  logic                               sclk,
    input  logic [3:0]                         io_in,
    input  logic                               qpi_en,
    input  logic [4:0]                         bp,
    output logic [3:0]                         io_out,
    output logic [3:0]                         io_oe,
    output logic                               erase_start,
    output logic [ADDR_W-SECTOR_ADDR_BITS-1:0] erase_sector
);
    localparam int SECT_W     = ADDR_W - SECTOR_ADDR_BITS;
    localparam int FRAME_BITS = OPC_BITS + ADDR_W;
    localparam int CNT_CAP    = FRAME_BITS + OPC_BITS;
    localparam int CNT_W      = $clog2(CNT_CAP + 1);

    logic                  cs_low, cs_rise, cs_fall, sclk_rise, rd_start;
    logic [3:0]            io_s;
    logic [FRAME_BITS-1:0] bits;
    logic [CNT_W-1:0]      nbits;
    logic                  wel, busy;
    status_t               status;

    sfe_pin_sync u_sync (
        .clk(clk), .rst(rst),
        .pins('{cs_n: cs_n, sclk: sclk, io: io_in}),
        .cs_low(cs_low), .cs_rise(cs_rise), .cs_fall(cs_fall),
        .sclk_rise(sclk_rise), .io_s(io_s)
    );

    sfe_cmd_shift #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W), .CNT_CAP(CNT_CAP)) u_shift (
        .clk(clk), .rst(rst), .qpi(qpi_en), .cs_fall(cs_fall),
        .sclk_rise(sclk_rise), .io_s(io_s),
        .bits(bits), .nbits(nbits), .rd_start(rd_start)
    );

    sfe_erase_ctrl #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .ERASE_CYCLES(ERASE_CYCLES),
        .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)
    ) u_erase (
        .clk(clk), .rst(rst), .cs_rise(cs_rise), .bits(bits), .nbits(nbits),
        .bp(bp), .wel(wel), .busy(busy),
        .erase_start(erase_start), .erase_sector(erase_sector)
    );

    assign status = '{rsvd: 1'b0, bp: bp, wel: wel, wip: busy};

    sfe_status_tx u_tx (
        .clk(clk), .rst(rst), .qpi(qpi_en), .rd_start(rd_start),
        .cs_low(cs_low), .sclk_rise(sclk_rise), .status(status),
        .io_out(io_out), .io_oe(io_oe)
    );
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker
    import sfe_pkg::*;
#(
    parameter int SECT_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              erase_start,
    input logic [SECT_W-1:0] erase_sector,
    input logic [4:0]        bp,
    input logic              wel,
    input logic              busy,
    input logic [3:0]        io_oe
);
    // R2
    start_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> $past(wel));

    // R8
    start_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> !sector_locked(32'(erase_sector), SECT_W, $past(bp)));

    // R4
    start_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        erase_start |=> !erase_start);

    // R5
    busy_rises_with_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> erase_start);

    // R6
    wel_clear_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        erase_start |=> !wel);

    // R7
    no_wel_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !wel);

    // R9
    oe_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        (io_oe == 4'h0) || (io_oe == 4'h2) || (io_oe == 4'hF));
endmodule

bind flash_sector_erase sfe_checker #(.SECT_W(SECT_W)) u_chk (
    .clk(clk), .rst(rst), .erase_start(erase_start), .erase_sector(erase_sector),
    .bp(bp), .wel(wel), .busy(busy), .io_oe(io_oe)
);

// File: tb/flash_sector_erase_test.sv
module flash_sector_erase_test;
    localparam int ERASE_CYC = 300;

    logic        clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, qpi_en = 1'b0;
    logic [3:0]  io_in = 4'h0;
    logic [4:0]  bp = 5'd0;
    logic [3:0]  io_out, io_oe;
    logic        erase_start;
    logic [11:0] erase_sector;

    int n_checks = 0, n_fails = 0, pulses = 0;
    logic [11:0] last_sector = '0;
    bit done = 0;

    flash_sector_erase #(.ERASE_CYCLES(ERASE_CYC)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .io_in(io_in),
        .qpi_en(qpi_en), .bp(bp), .io_out(io_out), .io_oe(io_oe),
        .erase_start(erase_start), .erase_sector(erase_sector)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst && erase_start) begin
            pulses      <= pulses + 1;
            last_sector <= erase_sector;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_locked(input int sector, input int level);
        int span;
        if (level == 0) return 0;
        if (level - 1 >= 12) return 1;
        span = 1 << (level - 1);
        return sector >= 4096 - span;
    endfunction

    function automatic int exp_status(input int wip, input int wel, input int level);
        return (level << 2) | (wel << 1) | wip;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clk_unit(input logic [3:0] v);
        io_in = v;
        wait_clk(4);
        sclk = 1'b1;
        wait_clk(4);
        sclk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        if (qpi_en) begin
            for (int i = n / 4 - 1; i >= 0; i--) clk_unit(v[4*i +: 4]);
        end else begin
            for (int i = n - 1; i >= 0; i--) clk_unit({3'b000, v[i]});
        end
    endtask

    task automatic frame(input logic [31:0] v, input int n);
        cs_n = 1'b0;
        wait_clk(4);
        send(v, n);
        wait_clk(4);
        cs_n = 1'b1;
        io_in = 4'h0;
        wait_clk(8);
    endtask

    task automatic read_status(output int s, output int oe);
        logic [7:0] acc;
        acc = '0;
        cs_n = 1'b0;
        wait_clk(4);
        send(32'h05, 8);
        oe = 0;
        for (int i = 0; i < (qpi_en ? 2 : 8); i++) begin
            wait_clk(4);
            oe = int'(io_oe);
            acc = qpi_en ? {acc[3:0], io_out} : {acc[6:0], io_out[1]};
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
        cs_n = 1'b1;
        wait_clk(8);
        s = int'(acc);
    endtask

    task automatic status_is(input int exp, input string req);
        int s, oe;
        read_status(s, oe);
        check(s == exp, req, s, exp);
    endtask

    task automatic try_erase(input logic [23:0] addr, input int n, input bit expect_go,
                             input string req);
        int p0;
        p0 = pulses;
        frame({8'h20, addr}, n);
        wait_clk(2);
        check((pulses - p0) == int'(expect_go), req, pulses - p0, int'(expect_go));
        if (expect_go)
            check(last_sector == addr[23:12], {req, " sector"}, last_sector, addr[23:12]);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int s, oe;
        void'($urandom(32'd20240611));
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);

        // R10 reset state
        check(erase_start == 1'b0, "R10 erase_start", erase_start, 0);
        check(io_oe == 4'h0, "R10 io_oe", io_oe, 0);
        read_status(s, oe);
        check(s == 0, "R10 status", s, 0);
        check(oe == 2, "R9 spi oe", oe, 2);

        // R2 erase without write enable
        try_erase(24'h123456, 32, 0, "R2 no wel");
        frame(32'h06, 8);
        status_is(exp_status(0, 1, 0), "R2 wel set");

        // R3 short and long frames
        frame({8'h20, 24'h123456} >> 8, 24);
        check(pulses == 0, "R3 short frame", pulses, 0);
        cs_n = 1'b0; wait_clk(4); send({8'h20, 24'h123456}, 32); send(32'h1, 1);
        wait_clk(4); cs_n = 1'b1; wait_clk(10);
        check(pulses == 0, "R3 long frame", pulses, 0);
        status_is(exp_status(0, 1, 0), "R3 wel kept");

        // R4 R5 R6 accepted erase in single-line mode
        try_erase(24'h5A7FFF, 32, 1, "R4 spi erase");
        status_is(exp_status(1, 0, 0), "R6 wip set wel clear");
        // R7 write enable during erase ignored
        frame(32'h06, 8);
        wait_clk(ERASE_CYC);
        status_is(exp_status(0, 0, 0), "R7 wren ignored while busy");
        try_erase(24'h5A7000, 32, 0, "R7 no new wel");

        // R5 busy lifetime, R1 four-line frames
        qpi_en = 1'b1;
        frame(32'h06, 8);
        status_is(exp_status(0, 1, 0), "R9 qpi status");
        read_status(s, oe);
        check(oe == 15, "R9 qpi oe", oe, 15);
        try_erase(24'h5A7000, 32, 1, "R1 qpi erase same sector R4");
        status_is(exp_status(1, 0, 0), "R5 wip during erase");
        wait_clk(ERASE_CYC);
        status_is(exp_status(0, 0, 0), "R5 wip ends");

        // R8 protection boundaries
        qpi_en = 1'b0;
        bp = 5'd3;
        frame(32'h06, 8);
        try_erase(24'hFFC000, 32, 0, "R8 locked edge");
        status_is(exp_status(0, 1, 3), "R8 wel kept");
        try_erase(24'hFFBFFF, 32, 1, "R8 unlocked edge");
        wait_clk(ERASE_CYC);
        bp = 5'd20;
        frame(32'h06, 8);
        try_erase(24'h000000, 32, 0, "R8 all locked");
        bp = 5'd1;
        try_erase(24'hFFF123, 32, 0, "R8 top sector");
        try_erase(24'hFFE123, 32, 1, "R8 next sector");
        wait_clk(ERASE_CYC);

        // R1 R4 R8 random frames
        for (int it = 0; it < 40; it++) begin
            logic [23:0] a;
            int lv;
            bit go;
            qpi_en = 1'($urandom_range(0, 1));
            lv = $urandom_range(0, 14);
            bp = 5'(lv);
            a = 24'($urandom);
            if (it % 3 == 0) a[23:20] = 4'hF;
            go = !exp_locked(int'(a[23:12]), lv);
            frame(32'h06, 8);
            try_erase(a, 32, go, "R8 random erase R1");
            if (go) begin
                status_is(exp_status(1, 0, lv), "R5 random busy");
                wait_clk(ERASE_CYC);
                status_is(exp_status(0, 0, lv), "R5 random idle");
            end else begin
                status_is(exp_status(0, 1, lv), "R8 random refused");
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule